// File: doc/BRIEF.md
# Variable-Stage Carry Select Adder

This block is a purely combinational 32-bit binary adder. It takes two operands and a carry-in and returns a 32-bit sum and a carry-out. The operand bits are split into a chain of stages. The first, least significant stage is a plain ripple adder fed by the external carry-in. Every later stage holds two ripple adders of its own width. One assumes an incoming carry of 0 and the other assumes 1. A multiplexer then picks the right sum and carry pair once the carry chosen by the stage below arrives.

The stage widths get larger toward the most significant end. A wider stage has more time to settle its two candidates while the selecting carry climbs the multiplexer chain, so its local result is ready about when the carry reaches it. The widths are a parameter array. The default split is 2,2,3,4,5,7,9. Elaboration rejects any list that does not sum to the operand width, and any list that shrinks toward the top.

Top module: `vcsa_adder`

## Requirements
- R1: For every input combination, {co, sum} equals the 33-bit arithmetic value of op_a + op_b + ci.
- R2: co is 1 exactly when the true total exceeds 2^32 - 1; for example, op_a = 32'hFFFFFFFF, op_b = 1, ci = 0 gives sum 0 and co 1.
- R3: The stage widths are set by the parameter array SEG_W. Elaboration fails if its entries do not sum to DATA_W. The default split is 2,2,3,4,5,7,9, so stages start at bits 0, 2, 4, 7, 11, 16 and 23.
- R4: Elaboration fails if any entry of SEG_W is narrower than the entry before it.
- R5: The lowest stage is a ripple adder whose carry-in is ci itself, so ci alone can change sum[0].
- R6: In every upper stage, the carry-1 candidate {carry, sum} equals the carry-0 candidate plus one, modulo 2^(width+1).
- R7: In every upper stage, the carry-1 candidate's carry-out is never 0 while the carry-0 candidate's carry-out is 1.
- R8: A carry raised at the top bit of any stage reaches the following stage. A carry raised in the lowest stage travels through every multiplexer to co.
- R9: With op_a all ones, op_b = 0 and ci = 1, the result is sum 0 and co 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_W (32) | First addend |
| op_b | input | DATA_W (32) | Second addend |
| ci | input | 1 | Carry into bit 0 |
| sum | output | DATA_W (32) | Sum bits |
| co | output | 1 | Carry out of the top bit |

## Verification
The bench aims at carries that cross stage boundaries. For each default boundary it builds an operand that generates a carry in the top bit of the stage below. A multiplexer wired to the wrong carry, or a stage offset one bit off, would leave the bit above the boundary wrong. The longest chains, all ones plus one and all ones plus only the carry-in, show whether a break anywhere in the multiplexer chain reaches co. Alternating bit patterns and carry-in toggling show whether the candidate adders swapped their assumed carries or whether the lowest stage ignores ci. Random vectors cover everything else.

// File: rtl/vcsa_pkg.sv
package vcsa_pkg;

  // Sum bit of a one-bit full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // Carry bit of a one-bit full adder (generate OR propagate-and-carry)
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

endpackage

// File: rtl/vcsa_ripple.sv
module vcsa_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import vcsa_pkg::*;

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]       = fa_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = fa_carry(x[i], y[i], chain[i]);
  end

  assign cout = chain[W];

endmodule

// File: rtl/vcsa_select_stage.sv
module vcsa_select_stage #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel_c,
  output logic [W-1:0] s,
  output logic         cout
);

  // Candidate results for both possible incoming carries
  logic [W-1:0] sum_if0;
  logic [W-1:0] sum_if1;
  logic         car_if0;
  logic         car_if1;

  vcsa_ripple #(.W(W)) rip0_i (
    .x(x), .y(y), .cin(1'b0), .s(sum_if0), .cout(car_if0)
  );

  vcsa_ripple #(.W(W)) rip1_i (
    .x(x), .y(y), .cin(1'b1), .s(sum_if1), .cout(car_if1)
  );

  // Selection by the carry chosen one stage below
  assign s    = sel_c ? sum_if1 : sum_if0;
  assign cout = sel_c ? car_if1 : car_if0;

  // Wider copies of the two candidates for the relation checks
  logic [W:0] cand0_w;
  logic [W:0] cand1_w;
  assign cand0_w = {car_if0, sum_if0};
  assign cand1_w = {car_if1, sum_if1};

  always_comb begin
    // R6
    pair_step_chk: assert (cand1_w == cand0_w + {{W{1'b0}}, 1'b1})
      else $error("carry-1 candidate is not carry-0 candidate plus one");
    // R7
    carry_order_chk: assert (!(car_if0 && !car_if1))
      else $error("carry-0 candidate carries while carry-1 candidate does not");
  end

endmodule

// File: rtl/vcsa_adder.sv
module vcsa_adder #(
  parameter int unsigned DATA_W            = 32,
  parameter int unsigned NSEG              = 7,
  parameter int unsigned SEG_W [NSEG]      = '{2, 2, 3, 4, 5, 7, 9}
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              ci,
  output logic [DATA_W-1:0] sum,
  output logic              co
);

  // Lowest bit index of stage k
  function automatic int unsigned seg_lo(input int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < k; j++) acc += SEG_W[j];
    return acc;
  endfunction

  // 1 when no stage is narrower than the one below it
  function automatic bit widths_grow();
    bit ok;
    ok = 1'b1;
    for (int unsigned j = 1; j < NSEG; j++)
      if (SEG_W[j] < SEG_W[j-1]) ok = 1'b0;
    return ok;
  endfunction

  localparam int unsigned TOTAL_W = seg_lo(NSEG);
  localparam bit          GROWS   = widths_grow();

  // R3: the stage widths must cover the operands exactly
  if (TOTAL_W != DATA_W) begin : g_bad_total
    $error("stage widths sum to %0d, expected %0d", TOTAL_W, DATA_W);
  end
  // R4: stage widths must not shrink toward the top
  if (!GROWS) begin : g_bad_order
    $error("stage widths must be non-decreasing");
  end

  // Carry into each stage; entry NSEG is the final carry
  logic [NSEG:0] seg_c;
  assign seg_c[0] = ci;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int unsigned LO = seg_lo(k);
    localparam int unsigned WK = SEG_W[k];
    if (k == 0) begin : g_first
      // R5: ripple stage driven straight from the external carry
      vcsa_ripple #(.W(WK)) first_i (
        .x(op_a[LO +: WK]), .y(op_b[LO +: WK]), .cin(seg_c[0]),
        .s(sum[LO +: WK]), .cout(seg_c[1])
      );
    end else begin : g_sel
      vcsa_select_stage #(.W(WK)) sel_i (
        .x(op_a[LO +: WK]), .y(op_b[LO +: WK]), .sel_c(seg_c[k]),
        .s(sum[LO +: WK]), .cout(seg_c[k+1])
      );
    end
  end

  assign co = seg_c[NSEG];

  // Arithmetic total computed apart from the stage chain
  logic [DATA_W:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, ci};

  always_comb begin
    // R1
    total_sum_chk: assert ({co, sum} == ref_total)
      else $error("stage chain result differs from arithmetic total");
    // R2
    carry_out_chk: assert (co == ref_total[DATA_W])
      else $error("carry-out differs from overflow of the total");
  end

endmodule

// File: tb/vcsa_adder_tb.sv
`timescale 1ns/1ps
module vcsa_adder_tb_top;

  localparam int unsigned DW = 32;

  logic [DW-1:0] op_a;
  logic [DW-1:0] op_b;
  logic          ci;
  logic [DW-1:0] sum;
  logic          co;
  logic          clk;

  int n_checks;
  int n_fails;
  bit done;

  vcsa_adder dut_i (
    .op_a(op_a), .op_b(op_b), .ci(ci), .sum(sum), .co(co)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Model: widen the operands and add, then split the result
  function automatic logic [DW:0] model_add(logic [DW-1:0] a, logic [DW-1:0] b, logic c);
    logic [DW:0] t;
    t = {1'b0, a};
    t = t + {1'b0, b};
    if (c) t = t + 1;
    return t;
  endfunction

  task automatic apply_check(input logic [DW-1:0] a, input logic [DW-1:0] b,
                             input logic c, input string req);
    logic [DW:0] exp_v;
    @(negedge clk);
    op_a = a; op_b = b; ci = c;
    #1;
    exp_v = model_add(a, b, c);
    n_checks++;
    if ({co, sum} !== exp_v) begin
      n_fails++;
      $display("FAIL %s: a=%h b=%h ci=%b got co=%b sum=%h expected co=%b sum=%h",
               req, a, b, c, co, sum, exp_v[DW], exp_v[DW-1:0]);
    end
  endtask

  // Idle inputs give a zero result
  task automatic t_idle();
    apply_check('0, '0, 1'b0, "R1 idle");
  endtask

  // R2, R8: all ones plus one ripples through every multiplexer
  task automatic t_all_ones();
    apply_check('1, 32'd1, 1'b0, "R2 R8 all ones plus one");
    apply_check(32'd1, '1, 1'b0, "R2 operands swapped");
    apply_check('1, '1, 1'b1, "R2 max plus max plus ci");
  endtask

  // R9: only the carry-in starts the chain
  task automatic t_cin_chain();
    apply_check('1, '0, 1'b1, "R9 all ones plus ci");
    apply_check('0, '1, 1'b1, "R9 ci into op_b all ones");
  endtask

  // R5: the carry-in reaches bit 0 through the lowest stage
  task automatic t_cin_low();
    apply_check('0, '0, 1'b1, "R5 ci alone");
    apply_check(32'h0000_0001, 32'h0, 1'b1, "R5 ci plus low bit");
  endtask

  // R6 R7: alternating patterns drive both candidates apart
  task automatic t_alternating();
    apply_check(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R6 alt no ci");
    apply_check(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R7 alt with ci");
    apply_check(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R6 alt self");
    apply_check(32'h5555_5555, 32'h5555_5555, 1'b1, "R7 alt self ci");
  endtask

  // R3 R4 R8: a carry made at the top of each default stage
  // (stage starts 2,4,7,11,16,23)
  task automatic t_boundaries();
    int unsigned starts [6] = '{2, 4, 7, 11, 16, 23};
    foreach (starts[i]) begin
      logic [DW-1:0] low_ones;
      low_ones = (32'd1 << starts[i]) - 32'd1;
      apply_check(low_ones, 32'd1, 1'b0, "R3 R8 boundary carry");
      apply_check(low_ones, 32'd0, 1'b1, "R4 R8 boundary ci carry");
      apply_check(32'd1 << (starts[i] - 1), 32'd1 << (starts[i] - 1), 1'b0,
                  "R8 boundary generate");
    end
  endtask

  // R1: random vectors
  task automatic t_random();
    for (int i = 0; i < 4000; i++) begin
      apply_check($urandom, $urandom, 1'($urandom), "R1 random");
    end
  endtask

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    op_a = '0; op_b = '0; ci = 1'b0;
    t_idle();
    t_all_ones();
    t_cin_chain();
    t_cin_low();
    t_alternating();
    t_boundaries();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule